// File: doc/BRIEF.md
# One-Hot Circular Buffer Pointer Pair

This block holds the write and read positions of a circular buffer built from 16 storage banks. Each position is kept as a one-hot mask: a word of zeros with a single set bit that marks the current bank. Pushing or popping k entries moves the matching mask by a logarithmic barrel rotation of k places. The wrap from the top bank back to bank 0 is part of the rotation, so the pointer path has no adder, no modulo logic and no comparator.

The masks go straight out as per-bank enables. The write-enable mask selects the bank that the next pushed entry lands in. The read-select mask selects the bank that the next popped entry comes from. No binary-to-one-hot decoder is needed on either side.

An occupancy counter decides whether each request is accepted. A push that would overfill the buffer, or a pop that asks for more entries than are held, is refused. The pointer stays where it is and a one-cycle error pulse is raised. The data storage itself lies outside this block.

Top module: `obp_ring_ptr`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises, wr_en_o and rd_sel_o both equal 16'h0001 (bank 0), count_o is 0, and both error outputs are 0.
- R2: wr_en_o and rd_sel_o each have exactly one bit set in every cycle.
- R3: An accepted push of step k (push_i high and count_o + k <= 16) moves the set bit of wr_en_o from bank p to bank (p + k) mod 16 at the next clock edge, and count_o rises by k.
- R4: An accepted pop of step k (pop_i high and k <= count_o) moves the set bit of rd_sel_o from bank p to bank (p + k) mod 16 at the next clock edge, and count_o falls by k.
- R5: A push or pop with a step of 0 leaves its mask and count_o unchanged and raises no error.
- R6: A push with count_o + k > 16 is refused. wr_en_o does not change, the push does not change count_o, and push_err_o is 1 for exactly the following cycle.
- R7: A pop with k > count_o is refused. rd_sel_o does not change, the pop does not change count_o, and pop_err_o is 1 for exactly the following cycle.
- R8: When a push and a pop are both accepted in the same cycle, both masks move, and count_o changes by the push step minus the pop step. Acceptance of each request is judged against count_o before the edge.
- R9: count_o never exceeds 16, and wr_en_o always equals rd_sel_o rotated left by count_o places.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Push request strobe |
| push_step_i | input | 4 | Number of entries pushed (0 to 15) |
| pop_i | input | 1 | Pop request strobe |
| pop_step_i | input | 4 | Number of entries popped (0 to 15) |
| wr_en_o | output | 16 | One-hot write-enable mask, bit j selects bank j |
| rd_sel_o | output | 16 | One-hot read-select mask, bit j selects bank j |
| count_o | output | 5 | Number of entries held (0 to 16) |
| push_err_o | output | 1 | One-cycle pulse after a refused push |
| pop_err_o | output | 1 | One-cycle pulse after a refused pop |

## Verification
Directed sequences cover four cases. The single-bit steps 1, 2, 4 and 8 each isolate one rotation stage. Steps that carry the mask past bank 15 show that the wrap is correct. Filling to exactly 16 and then asking for one more separates the inclusive full limit from the refusal. Popping one more entry than is held does the same at the empty end. A long random run then mixes pushes, pops and simultaneous pairs of every step size against a bench model that tracks positions as integers. This exposes a wrong rotation direction, a wrong acceptance limit and a wrong net count, which the directed cases alone can miss.

// File: rtl/obp_pkg.sv
package obp_pkg;
  localparam int unsigned OBP_DEF_BANKS = 16;

  // Rotation wrap equals modulo only for a power-of-two bank count
  function automatic bit obp_is_pow2(input int unsigned n);
    return (n != 0) && ((n & (n - 1)) == 0);
  endfunction

  typedef enum logic [1:0] {
    OBP_IDLE   = 2'b00,
    OBP_ACCEPT = 2'b01,
    OBP_REFUSE = 2'b10
  } obp_req_e;
endpackage

// File: rtl/obp_mask_rotator.sv
module obp_mask_rotator #(
  parameter int unsigned N      = 16,
  parameter int unsigned STEP_W = $clog2(N)
) (
  input  logic [N-1:0]      mask_i,
  input  logic [STEP_W-1:0] step_i,
  output logic [N-1:0]      mask_o
);
  logic [N-1:0] stage_q [STEP_W+1];

  assign stage_q[0] = mask_i;

  // stage s rotates left by 2**s when step bit s is set
  for (genvar s = 0; s < STEP_W; s++) begin : g_stage
    localparam int unsigned SH = (1 << s) % N;
    if (SH == 0) begin : g_full
      assign stage_q[s+1] = stage_q[s];
    end else begin : g_rot
      assign stage_q[s+1] = step_i[s]
        ? {stage_q[s][N-1-SH:0], stage_q[s][N-1:N-SH]}
        : stage_q[s];
    end
  end

  assign mask_o = stage_q[STEP_W];
endmodule

// File: rtl/obp_onehot_ptr.sv
module obp_onehot_ptr #(
  parameter int unsigned N      = 16,
  parameter int unsigned STEP_W = $clog2(N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  input  logic [STEP_W-1:0] step_i,
  output logic [N-1:0]      mask_o
);
  localparam logic [N-1:0] RST_MASK = {{(N-1){1'b0}}, 1'b1};

  logic [N-1:0] mask_q;
  logic [N-1:0] rot_mask;

  obp_mask_rotator #(
    .N      (N),
    .STEP_W (STEP_W)
  ) rot_i (
    .mask_i (mask_q),
    .step_i (step_i),
    .mask_o (rot_mask)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= RST_MASK;
    end else if (adv_i) begin
      mask_q <= rot_mask;
    end
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/obp_occupancy.sv
module obp_occupancy
  import obp_pkg::*;
#(
  parameter int unsigned N      = 16,
  parameter int unsigned STEP_W = $clog2(N),
  parameter int unsigned CNT_W  = $clog2(N + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [STEP_W-1:0] push_step_i,
  input  logic              pop_i,
  input  logic [STEP_W-1:0] pop_step_i,
  output logic              push_go_o,
  output logic              pop_go_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              push_err_o,
  output logic              pop_err_o
);
  localparam int unsigned SUM_W = CNT_W + 1;
  localparam logic [SUM_W-1:0] LIMIT = SUM_W'(N);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [SUM_W-1:0] push_sum;
  logic             push_fits, pop_fits;
  obp_req_e         push_st, pop_st;
  logic             push_err_q, pop_err_q;

  // both limits judged on the pre-edge count
  assign push_sum  = SUM_W'(cnt_q) + SUM_W'(push_step_i);
  assign push_fits = push_sum <= LIMIT;
  assign pop_fits  = SUM_W'(pop_step_i) <= SUM_W'(cnt_q);

  always_comb begin
    push_st = OBP_IDLE;
    if (push_i) push_st = push_fits ? OBP_ACCEPT : OBP_REFUSE;
    pop_st = OBP_IDLE;
    if (pop_i) pop_st = pop_fits ? OBP_ACCEPT : OBP_REFUSE;
  end

  assign push_go_o = (push_st == OBP_ACCEPT);
  assign pop_go_o  = (pop_st == OBP_ACCEPT);

  always_comb begin
    cnt_d = cnt_q;
    if (push_go_o) cnt_d = cnt_d + CNT_W'(push_step_i);
    if (pop_go_o)  cnt_d = cnt_d - CNT_W'(pop_step_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      push_err_q <= 1'b0;
      pop_err_q  <= 1'b0;
    end else begin
      cnt_q      <= cnt_d;
      push_err_q <= (push_st == OBP_REFUSE);
      pop_err_q  <= (pop_st == OBP_REFUSE);
    end
  end

  assign count_o    = cnt_q;
  assign push_err_o = push_err_q;
  assign pop_err_o  = pop_err_q;
endmodule

// File: rtl/obp_ring_ptr.sv
module obp_ring_ptr
  import obp_pkg::*;
#(
  parameter int unsigned N_BANKS = OBP_DEF_BANKS,
  parameter int unsigned STEP_W  = $clog2(N_BANKS),
  parameter int unsigned CNT_W   = $clog2(N_BANKS + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               push_i,
  input  logic [STEP_W-1:0]  push_step_i,
  input  logic               pop_i,
  input  logic [STEP_W-1:0]  pop_step_i,
  output logic [N_BANKS-1:0] wr_en_o,
  output logic [N_BANKS-1:0] rd_sel_o,
  output logic [CNT_W-1:0]   count_o,
  output logic               push_err_o,
  output logic               pop_err_o
);
  initial begin
    if (!obp_is_pow2(N_BANKS)) $error("N_BANKS must be a power of two");
  end

  logic push_go, pop_go;

  obp_occupancy #(
    .N      (N_BANKS),
    .STEP_W (STEP_W),
    .CNT_W  (CNT_W)
  ) occ_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push_i),
    .push_step_i (push_step_i),
    .pop_i       (pop_i),
    .pop_step_i  (pop_step_i),
    .push_go_o   (push_go),
    .pop_go_o    (pop_go),
    .count_o     (count_o),
    .push_err_o  (push_err_o),
    .pop_err_o   (pop_err_o)
  );

  obp_onehot_ptr #(
    .N      (N_BANKS),
    .STEP_W (STEP_W)
  ) wr_ptr_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (push_go),
    .step_i (push_step_i),
    .mask_o (wr_en_o)
  );

  obp_onehot_ptr #(
    .N      (N_BANKS),
    .STEP_W (STEP_W)
  ) rd_ptr_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (pop_go),
    .step_i (pop_step_i),
    .mask_o (rd_sel_o)
  );
endmodule

// File: rtl/obp_ring_ptr_chk.sv
module obp_ring_ptr_chk #(
  parameter int unsigned N_BANKS = 16,
  parameter int unsigned STEP_W  = 4,
  parameter int unsigned CNT_W   = 5
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               push_i,
  input logic [STEP_W-1:0]  push_step_i,
  input logic               pop_i,
  input logic [STEP_W-1:0]  pop_step_i,
  input logic [N_BANKS-1:0] wr_en_o,
  input logic [N_BANKS-1:0] rd_sel_o,
  input logic [CNT_W-1:0]   count_o,
  input logic               push_err_o,
  input logic               pop_err_o
);
  function automatic logic [N_BANKS-1:0] rotl(input logic [N_BANKS-1:0] m,
                                              input int unsigned k);
    logic [N_BANKS-1:0] r;
    r = '0;
    for (int unsigned i = 0; i < N_BANKS; i++) r[(i + k) % N_BANKS] = m[i];
    return r;
  endfunction

  logic push_ok_m, pop_ok_m;
  assign push_ok_m = (int'(count_o) + int'(push_step_i)) <= int'(N_BANKS);
  assign pop_ok_m  = int'(pop_step_i) <= int'(count_o);

  p_wr_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(wr_en_o) == 1);
  p_rd_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(rd_sel_o) == 1);
  p_push_rot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && push_ok_m |=> wr_en_o == rotl($past(wr_en_o), $past(push_step_i)));
  p_pop_rot_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i && pop_ok_m |=> rd_sel_o == rotl($past(rd_sel_o), $past(pop_step_i)));
  p_idle_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !push_i && !pop_i |=> $stable(count_o) && $stable(wr_en_o) && $stable(rd_sel_o));
  p_push_refuse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && !push_ok_m |=> push_err_o && $stable(wr_en_o));
  p_push_err_cause_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(push_i && !push_ok_m) |=> !push_err_o);
  p_pop_refuse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i && !pop_ok_m |=> pop_err_o && $stable(rd_sel_o));
  p_pop_err_cause_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pop_i && !pop_ok_m) |=> !pop_err_o);
  p_net_count_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && pop_i && push_ok_m && pop_ok_m |=>
    int'(count_o) == int'($past(count_o)) + int'($past(push_step_i)) - int'($past(pop_step_i)));
  p_no_overflow_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(count_o) <= int'(N_BANKS));
  p_ring_gap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o == rotl(rd_sel_o, int'(count_o)));
endmodule

bind obp_ring_ptr obp_ring_ptr_chk #(
  .N_BANKS (N_BANKS),
  .STEP_W  (STEP_W),
  .CNT_W   (CNT_W)
) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .push_i      (push_i),
  .push_step_i (push_step_i),
  .pop_i       (pop_i),
  .pop_step_i  (pop_step_i),
  .wr_en_o     (wr_en_o),
  .rd_sel_o    (rd_sel_o),
  .count_o     (count_o),
  .push_err_o  (push_err_o),
  .pop_err_o   (pop_err_o)
);

// File: tb/obp_ring_ptr_tb_top.sv
`timescale 1ns/1ps
module obp_ring_ptr_tb_top;
  localparam int NB = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        push = 1'b0, pop = 1'b0;
  logic [3:0]  push_k = '0, pop_k = '0;
  logic [15:0] wr_en, rd_sel;
  logic [4:0]  count;
  logic        push_err, pop_err;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int m_wr = 0, m_rd = 0, m_cnt = 0;
  bit m_perr = 0, m_qerr = 0;

  always #5 clk = ~clk;

  obp_ring_ptr dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .push_i      (push),
    .push_step_i (push_k),
    .pop_i       (pop),
    .pop_step_i  (pop_k),
    .wr_en_o     (wr_en),
    .rd_sel_o    (rd_sel),
    .count_o     (count),
    .push_err_o  (push_err),
    .pop_err_o   (pop_err)
  );

  function automatic logic [15:0] pos_mask(input int p);
    return 16'(1) << p;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_outputs(input string tw, input string tr, input string tc,
                               input string tpe, input string tqe);
    chk(tw, 32'(wr_en), 32'(pos_mask(m_wr)));
    chk(tr, 32'(rd_sel), 32'(pos_mask(m_rd)));
    chk(tc, 32'(count), 32'(m_cnt));
    chk(tpe, 32'(push_err), 32'(m_perr));
    chk(tqe, 32'(pop_err), 32'(m_qerr));
    chk("R2", 32'($countones(wr_en) == 1 && $countones(rd_sel) == 1), 32'(1));
  endtask

  // one request cycle: drive at negedge, model, check after the edge
  task automatic step(input bit pu, input int pk, input bit po, input int qk);
    bit pok, qok;
    string tw, tr, tc, tpe, tqe;
    push = pu; push_k = 4'(pk); pop = po; pop_k = 4'(qk);
    pok = (m_cnt + pk) <= NB;
    qok = qk <= m_cnt;
    tw = !pu ? "R5" : !pok ? "R6" : (pk == 0) ? "R5" : "R3";
    tr = !po ? "R5" : !qok ? "R7" : (qk == 0) ? "R5" : "R4";
    tc = (pu && po) ? "R8" : "R9";
    tpe = "R6";
    tqe = "R7";
    if (pu && pok) begin m_wr = (m_wr + pk) % NB; m_cnt += pk; end
    if (po && qok) begin m_rd = (m_rd + qk) % NB; m_cnt -= qk; end
    m_perr = pu && !pok;
    m_qerr = po && !qok;
    @(posedge clk);
    #1;
    check_outputs(tw, tr, tc, tpe, tqe);
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    int seed;
    seed = 32'h5eed_0b0f;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    check_outputs("R1", "R1", "R1", "R1", "R1");
    rst_n = 1'b1;
    @(posedge clk); #1;
    check_outputs("R1", "R1", "R1", "R1", "R1");
    @(negedge clk);

    // zero steps
    step(1, 0, 0, 0);
    step(0, 0, 1, 0);
    step(1, 0, 1, 0);
    // single-stage steps and wrap
    step(1, 1, 0, 0);
    step(1, 2, 0, 0);
    step(1, 4, 0, 0);
    step(1, 8, 0, 0);   // count 15
    step(1, 2, 0, 0);   // refused: 17 > 16
    step(0, 0, 0, 0);   // err pulse drops
    step(1, 1, 0, 0);   // exactly full, wr wraps to 0
    step(1, 1, 0, 0);   // refused at full
    step(0, 0, 1, 15);
    step(0, 0, 1, 2);   // refused: 2 > 1
    step(0, 0, 1, 1);   // empty, rd wraps
    step(0, 0, 1, 1);   // refused at empty
    step(1, 9, 1, 0);
    step(1, 7, 1, 5);   // simultaneous, net +2
    step(1, 15, 1, 11); // push refused, pop accepted
    step(1, 3, 1, 14);  // pop refused, push accepted

    for (int i = 0; i < 3000; i++) begin
      bit pu, po;
      int pk, qk;
      pu = ($urandom % 3) != 0;
      po = ($urandom % 3) != 0;
      pk = $urandom % 16;
      qk = $urandom % 16;
      if (($urandom % 4) == 0) pk = $urandom % 3;
      if (($urandom % 4) == 0) qk = m_cnt - ($urandom % 2);
      if (qk < 0) qk = 0;
      if (qk > 15) qk = 15;
      step(pu, pk, po, qk);
    end

    // async reset mid-run returns to bank 0
    push = 1; push_k = 4'd5;
    #2 rst_n = 1'b0;
    #1;
    m_wr = 0; m_rd = 0; m_cnt = 0; m_perr = 0; m_qerr = 0;
    check_outputs("R1", "R1", "R1", "R1", "R1");
    push = 0; push_k = '0;
    @(negedge clk);
    rst_n = 1'b1;
    step(1, 3, 0, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule